// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of binary ownership tokens that two processors, one on a left port and one on a right port, use to share resources. Each token is claimed by writing a zero to it and given back by writing a one. Only the current holder can give a token back. A claim made while the other side holds the token is not lost. It is remembered, and the token passes to the waiting side on the same clock edge that the holder releases it.

Each port has a semaphore select, a chip enable for the neighbouring memory, a write strobe, an output enable, a flag address and a byte-wide data path. The block is fully synchronous. Every access finishes in the cycle it is presented, so the ports have no valid/ready handshake and never apply back-pressure: a write counts on every clock edge where it is presented. A read captures the flag value as seen from the reading side when its read window opens. It holds that value while the window stays open, so a processor can poll without the data changing under it.

Top module: `sem_bank`

## Requirements
- R1: Address bits [2:0] select one of eight flags, and an access changes only the flag it addresses.
- R2: A write uses data bit 0 alone. Bit 0 = 0 is a claim and bit 0 = 1 is a release or withdrawal; bits [7:1] have no effect.
- R3: Read data repeats one flag state on all eight bits: 8'h00 when the reading side holds the flag and 8'hFF otherwise.
- R4: A claim on a free flag gives it to the claiming side, which then reads 8'h00 while the other side reads 8'hFF.
- R5: A held flag stays held until its holder writes a one. A one written by the holder with nothing pending frees the flag, and a one written by the other side does not change ownership.
- R6: A claim from the non-holding side is kept pending. When the holder releases, ownership moves to the pending side on that same clock edge.
- R7: A one written by a side that has a pending claim withdraws that claim, so a later release frees the flag.
- R8: When both sides claim a free flag in the same cycle, the left side wins and the right side's claim stays pending.
- R9: The read register loads on the first cycle in which select, output enable and a non-write access are all active. It then keeps its value, even if the address or the flags change, until the window closes.
- R10: An access counts only when select is high and chip enable is low. With both high, writes and reads have no effect.
- R11: After reset every flag is free, nothing is pending, and both read registers hold 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left semaphore select, active high |
| l_ce | input | 1 | Left memory chip enable, active high (must be low for semaphore access) |
| l_we | input | 1 | Left write strobe, high = write |
| l_oe | input | 1 | Left output enable, active high |
| l_addr | input | 3 | Left flag address |
| l_wdata | input | 8 | Left write data (bit 0 used) |
| l_rdata | output | 8 | Left read data |
| r_sel | input | 1 | Right semaphore select, active high |
| r_ce | input | 1 | Right memory chip enable, active high |
| r_we | input | 1 | Right write strobe |
| r_oe | input | 1 | Right output enable |
| r_addr | input | 3 | Right flag address |
| r_wdata | input | 8 | Right write data (bit 0 used) |
| r_rdata | output | 8 | Right read data |

## Verification
The bench targets four cases: the handoff of a pending claim, the withdrawal of that claim, a tie between the two sides, and a read window that stays open while the address changes. A design that dropped the pending claim would leave the flag free after the release. One that transferred the claim a cycle late would show both sides reading 8'hFF for one poll. A design that arbitrated ties the wrong way would hand the flag to the right side. A design whose read register follows its input would pick up the newly addressed flag in the middle of the window. The bench also writes with bit 0 and the upper bits set to opposite values, and it presents accesses with select and chip enable both high; any leak from either shows up as a changed read.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } sem_owner_e;
endpackage

// File: rtl/sem_flag.sv
module sem_flag
  import sem_bank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_l,
  input  logic bit_l,
  input  logic wr_r,
  input  logic bit_r,
  output logic own_l,
  output logic own_r
);
  logic       want_l, want_r;
  logic       want_l_nx, want_r_nx;
  sem_owner_e owner, owner_nx;

  // a side's request latch follows its own writes: bit 0 low = wants token
  always_comb begin
    want_l_nx = wr_l ? ~bit_l : want_l;
    want_r_nx = wr_r ? ~bit_r : want_r;
    if (owner == OWN_LEFT && want_l_nx)        owner_nx = OWN_LEFT;
    else if (owner == OWN_RIGHT && want_r_nx)  owner_nx = OWN_RIGHT;
    else if (want_l_nx)                        owner_nx = OWN_LEFT;
    else if (want_r_nx)                        owner_nx = OWN_RIGHT;
    else                                       owner_nx = OWN_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_l <= 1'b0;
      want_r <= 1'b0;
      owner  <= OWN_NONE;
    end else begin
      want_l <= want_l_nx;
      want_r <= want_r_nx;
      owner  <= owner_nx;
    end
  end

  assign own_l = (owner == OWN_LEFT);
  assign own_r = (owner == OWN_RIGHT);

  AST_HOLDER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l && !(wr_l && bit_l)) |=> own_l); // R5
  AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l && wr_l && bit_l && !want_r && !(wr_r && !bit_r)) |=> (!own_l && !own_r)); // R5
  AST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l && wr_l && bit_l && want_r && !(wr_r && bit_r)) |=> own_r); // R6
  AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!own_l && !own_r && wr_l && !bit_l && wr_r && !bit_r) |=> (own_l && want_r)); // R8
endmodule

// File: rtl/sem_rd_port.sv
module sem_rd_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win,
  input  logic          held,
  output logic [DW-1:0] rdata
);
  logic win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      rdata <= '1;
    end else begin
      win_q <= win;
      if (win && !win_q) rdata <= {DW{~held}};
    end
  end

  AST_RD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (win && win_q) |=> $stable(rdata)); // R9
  AST_RD_REPLICA: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata == '0) || (rdata == '1)); // R3
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NFLAG = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(NFLAG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_sel,
  input  logic          l_ce,
  input  logic          l_we,
  input  logic          l_oe,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          r_sel,
  input  logic          r_ce,
  input  logic          r_we,
  input  logic          r_oe,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata
);
  logic             acc_l, acc_r, wen_l, wen_r, win_l, win_r;
  logic [NFLAG-1:0] own_l_v, own_r_v;
  logic             held_l, held_r;

  // semaphore access only with select on and memory enable off
  assign acc_l = l_sel & ~l_ce;
  assign acc_r = r_sel & ~r_ce;
  assign wen_l = acc_l & l_we;
  assign wen_r = acc_r & r_we;
  assign win_l = acc_l & l_oe & ~l_we;
  assign win_r = acc_r & r_oe & ~r_we;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    sem_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_l  (wen_l && (l_addr == AW'(i))),
      .bit_l (l_wdata[0]),
      .wr_r  (wen_r && (r_addr == AW'(i))),
      .bit_r (r_wdata[0]),
      .own_l (own_l_v[i]),
      .own_r (own_r_v[i])
    );
  end

  assign held_l = own_l_v[l_addr];
  assign held_r = own_r_v[r_addr];

  sem_rd_port #(.DW(DW)) u_rd_l (
    .clk (clk), .rst_n (rst_n), .win (win_l), .held (held_l), .rdata (l_rdata)
  );
  sem_rd_port #(.DW(DW)) u_rd_r (
    .clk (clk), .rst_n (rst_n), .win (win_r), .held (held_r), .rdata (r_rdata)
  );

  AST_BLOCKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (l_sel && l_ce && !acc_r) |=> ($stable(own_l_v) && $stable(own_r_v))); // R10
  AST_NO_SHARED_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l_v & own_r_v) == '0); // R4
  AST_UPPER_BITS_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_l && !l_wdata[0] && (l_wdata[DW-1:1] != '0) && !own_r_v[l_addr] && !wen_r)
      |=> own_l_v[$past(l_addr)]); // R2
endmodule

// File: tb/tb_sem_bank.sv
`timescale 1ns/1ps
module tb_sem_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       l_sel = 0, l_ce = 0, l_we = 0, l_oe = 0;
  logic [2:0] l_addr = '0;
  logic [7:0] l_wdata = '0;
  logic [7:0] l_rdata;
  logic       r_sel = 0, r_ce = 0, r_we = 0, r_oe = 0;
  logic [2:0] r_addr = '0;
  logic [7:0] r_wdata = '0;
  logic [7:0] r_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sem_bank dut (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: owner 0 free, 1 left, 2 right
  int         m_own [8];
  bit         m_wl [8], m_wr [8];
  logic [7:0] m_rl = 8'hFF, m_rr = 8'hFF;
  bit         m_winl_q = 0, m_winr_q = 0;

  always @(posedge clk) begin
    bit accl, accr, winl, winr;
    if (!rst_n) begin
      foreach (m_own[i]) begin m_own[i] = 0; m_wl[i] = 0; m_wr[i] = 0; end
      m_rl = 8'hFF; m_rr = 8'hFF; m_winl_q = 0; m_winr_q = 0;
    end else begin
      accl = l_sel && !l_ce;
      accr = r_sel && !r_ce;
      winl = accl && l_oe && !l_we;
      winr = accr && r_oe && !r_we;
      if (winl && !m_winl_q) m_rl = (m_own[l_addr] == 1) ? 8'h00 : 8'hFF;
      if (winr && !m_winr_q) m_rr = (m_own[r_addr] == 2) ? 8'h00 : 8'hFF;
      m_winl_q = winl;
      m_winr_q = winr;
      if (accl && l_we) m_wl[l_addr] = !l_wdata[0];
      if (accr && r_we) m_wr[r_addr] = !r_wdata[0];
      foreach (m_own[i]) begin
        if (m_own[i] == 1 && m_wl[i])      m_own[i] = 1;
        else if (m_own[i] == 2 && m_wr[i]) m_own[i] = 2;
        else if (m_wl[i])                  m_own[i] = 1;
        else if (m_wr[i])                  m_own[i] = 2;
        else                               m_own[i] = 0;
      end
    end
    #1;
    chk("R3 R9 model left", l_rdata, m_rl);
    chk("R3 R9 model right", r_rdata, m_rr);
  end

  task automatic idle();
    l_sel = 0; l_ce = 0; l_we = 0; l_oe = 0;
    r_sel = 0; r_ce = 0; r_we = 0; r_oe = 0;
  endtask

  task automatic wrp(input bit right, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    if (right) begin r_sel = 1; r_we = 1; r_addr = a; r_wdata = d; end
    else begin l_sel = 1; l_we = 1; l_addr = a; l_wdata = d; end
    @(negedge clk);
    idle();
  endtask

  task automatic rdp(input bit right, input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    if (right) begin r_sel = 1; r_oe = 1; r_addr = a; end
    else begin l_sel = 1; l_oe = 1; l_addr = a; end
    @(posedge clk);
    #2;
    v = right ? r_rdata : l_rdata;
    @(negedge clk);
    idle();
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk("R11 reset left rdata", l_rdata, 8'hFF);
    chk("R11 reset right rdata", r_rdata, 8'hFF);
    rst_n = 1;
    for (int i = 0; i < 8; i++) begin
      rdp(0, 3'(i), v); chk("R11 left free after reset", v, 8'hFF);
      rdp(1, 3'(i), v); chk("R11 right free after reset", v, 8'hFF);
    end
    // claim by left
    wrp(0, 3, 8'hFE);
    rdp(0, 3, v); chk("R4 claimer reads 00", v, 8'h00);
    rdp(1, 3, v); chk("R4 other side reads FF", v, 8'hFF);
    rdp(0, 2, v); chk("R1 neighbour flag untouched", v, 8'hFF);
    rdp(0, 4, v); chk("R1 other neighbour untouched", v, 8'hFF);
    // bit 0 only
    wrp(0, 5, 8'h01);
    rdp(0, 5, v); chk("R2 bit0=1 upper zero no claim", v, 8'hFF);
    wrp(0, 5, 8'hAA);
    rdp(0, 5, v); chk("R2 bit0=0 upper set claims", v, 8'h00);
    // pending handoff
    wrp(1, 3, 8'h00);
    rdp(1, 3, v); chk("R6 pending side not yet holder", v, 8'hFF);
    rdp(0, 3, v); chk("R6 holder unchanged by claim", v, 8'h00);
    wrp(0, 3, 8'h01);
    rdp(1, 3, v); chk("R6 pending side gets token", v, 8'h00);
    rdp(0, 3, v); chk("R6 old holder reads FF", v, 8'hFF);
    // withdrawal
    wrp(0, 3, 8'h00);
    wrp(0, 3, 8'h01);
    wrp(1, 3, 8'h01);
    rdp(0, 3, v); chk("R7 withdrawn claim left", v, 8'hFF);
    rdp(1, 3, v); chk("R7 flag free after release", v, 8'hFF);
    // non-holder release ignored, holder release frees
    wrp(1, 5, 8'hFF);
    rdp(0, 5, v); chk("R5 other side release ignored", v, 8'h00);
    wrp(0, 5, 8'hFF);
    rdp(0, 5, v); chk("R5 holder release frees left", v, 8'hFF);
    rdp(1, 5, v); chk("R5 holder release frees right", v, 8'hFF);
    // tie
    @(negedge clk);
    l_sel = 1; l_we = 1; l_addr = 6; l_wdata = 8'h00;
    r_sel = 1; r_we = 1; r_addr = 6; r_wdata = 8'h00;
    @(negedge clk);
    idle();
    rdp(0, 6, v); chk("R8 tie left wins", v, 8'h00);
    rdp(1, 6, v); chk("R8 tie right loses", v, 8'hFF);
    wrp(0, 6, 8'h01);
    rdp(1, 6, v); chk("R8 right claim stayed pending", v, 8'h00);
    // disallowed combination
    @(negedge clk);
    l_sel = 1; l_ce = 1; l_we = 1; l_addr = 0; l_wdata = 8'h00;
    @(negedge clk);
    idle();
    rdp(0, 0, v); chk("R10 write with ce high ignored", v, 8'hFF);
    wrp(0, 7, 8'h00);
    rdp(0, 0, v);
    @(negedge clk);
    l_sel = 1; l_ce = 1; l_oe = 1; l_addr = 7;
    @(posedge clk); #2;
    chk("R10 read with ce high no capture", l_rdata, 8'hFF);
    @(negedge clk);
    idle();
    // read window frozen
    @(negedge clk);
    l_sel = 1; l_oe = 1; l_addr = 1;
    @(posedge clk); #2;
    chk("R9 window opens on free flag", l_rdata, 8'hFF);
    @(negedge clk);
    l_addr = 7;
    repeat (3) @(posedge clk);
    #2;
    chk("R9 value held across address change", l_rdata, 8'hFF);
    @(negedge clk);
    idle();
    rdp(0, 7, v); chk("R9 reopened window captures", v, 8'h00);
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule